// File: doc/BRIEF.md
# Doubleword/Word Rotate Unit

This block performs a left rotation on a 64-bit datapath operand. In doubleword mode, the full 64-bit operand rotates left. The rotate amount is the 6-bit amount taken modulo the datapath width. In word mode, the low 32 bits of the operand are first copied into both halves of a 64-bit value, and that value is then rotated by the same rule. The output therefore always holds the word rotation in both halves. A later masking stage can select whichever bits it needs from this doubled result.

An operation is presented with a valid strobe. The result and an output valid flag appear one clock later. When the strobe is low, the result register keeps its previous contents. The external reset is asynchronous and active low. Inside the block, its release is synchronised to the clock before it reaches the valid flag.

Top module: `rot_unit`

## Requirements
- R1: With `in_word` = 0 (doubleword mode), `out_data` equals `in_data` rotated left by `in_amt` positions. Bits leaving the top re-enter at bit 0. For example, 0xdeadbeef12345678 by 10 gives 0xb6fbbc48d159e37a, and by 35 gives 0x91a2b3c6f56df778.
- R2: With `in_word` = 1 (word mode), `in_data[63:32]` has no effect on the result. `out_data` is the 64-bit value {in_data[31:0], in_data[31:0]} rotated left by `in_amt`.
- R3: When `in_amt` = 0, the rotation step changes nothing. The result is `in_data` in doubleword mode and the duplicated low word in word mode.
- R4: In word mode, the two halves of `out_data` are equal, and each equals the low word rotated left by `in_amt` mod 32. For example, 0xdeadbeef by 10 gives 0xb6fbbf7a, and by 17 gives 0x7ddfbd5b.
- R5: `out_valid` in a cycle equals `in_valid` sampled at the previous rising clock edge. The result appears on `out_data` exactly one cycle after the operands are sampled.
- R6: When `in_valid` is low at a rising edge, `out_data` keeps its previous value, whatever the other inputs are.
- R7: While `rst_n` is low, `out_valid` is 0. It stays 0 until `in_valid` is sampled high after the internal reset release, which takes two clock edges.
- R8: The largest amount, 63, is handled as a rotation by 63, which is equivalent to a right rotation by one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation strobe |
| in_word | input | 1 | Mode select: 1 = word (duplicate low half), 0 = doubleword |
| in_amt | input | 6 | Left rotate amount |
| in_data | input | 64 | Operand |
| out_valid | output | 1 | Result valid, one cycle after in_valid |
| out_data | output | 64 | Registered rotated result |

## Verification
The assertions assume that `in_valid`, `in_word`, `in_amt` and `in_data` are stable, known values at each rising edge after reset. They also assume that `in_valid` stays low while the internal reset is active. This makes every `$past` term that refers to a sampled operation refer to real operands. The bench drives all inputs on the falling edge and holds `in_valid` low through reset. Its random stimulus comes only from `$urandom` after a fixed seed, so no input is ever left unknown while the checks are active.

// File: rtl/rot_pkg.sv
package rot_pkg;
  typedef enum logic {
    MODE_DWORD = 1'b0,
    MODE_WORD  = 1'b1
  } rot_mode_e;

  localparam int unsigned DEF_DATA_W = 64;
endpackage

// File: rtl/rot_reset_sync.sv
module rot_reset_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/rot_word_fold.sv
module rot_word_fold
  import rot_pkg::*;
#(
  parameter int unsigned DATA_W = DEF_DATA_W
) (
  input  logic [DATA_W-1:0] src,
  input  rot_mode_e         mode,
  output logic [DATA_W-1:0] folded
);
  localparam int unsigned HALF_W = DATA_W / 2;

  always_comb begin
    if (mode == MODE_WORD) folded = {src[HALF_W-1:0], src[HALF_W-1:0]};
    else                   folded = src;
  end
endmodule

// File: rtl/rot_barrel.sv
module rot_barrel #(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned AMT_W  = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] src,
  input  logic [AMT_W-1:0]  amt,
  output logic [DATA_W-1:0] rotated
);
  logic [DATA_W-1:0] stage [AMT_W+1];

  assign stage[0] = src;

  for (genvar k = 0; k < AMT_W; k++) begin : g_stage
    localparam int unsigned SH = 1 << k;
    logic [DATA_W-1:0] turned;
    assign turned = {stage[k][DATA_W-1-SH:0], stage[k][DATA_W-1:DATA_W-SH]};
    assign stage[k+1] = amt[k] ? turned : stage[k];
  end

  assign rotated = stage[AMT_W];
endmodule

// File: rtl/rot_unit.sv
module rot_unit
  import rot_pkg::*;
#(
  parameter int unsigned DATA_W = DEF_DATA_W,
  parameter int unsigned AMT_W  = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_word,
  input  logic [AMT_W-1:0]  in_amt,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data
);
  logic              rst_sync_n;
  rot_mode_e         mode;
  logic [DATA_W-1:0] folded;
  logic [DATA_W-1:0] rotated;
  logic [DATA_W-1:0] data_d, data_q;
  logic              valid_d, valid_q;

  assign mode = rot_mode_e'(in_word);

  rot_reset_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  rot_word_fold #(.DATA_W(DATA_W)) u_fold (
    .src(in_data), .mode(mode), .folded(folded)
  );

  rot_barrel #(.DATA_W(DATA_W), .AMT_W(AMT_W)) u_rot (
    .src(folded), .amt(in_amt), .rotated(rotated)
  );

  always_comb begin
    data_d  = in_valid ? rotated : data_q;
    valid_d = in_valid;
  end

  always_ff @(posedge clk) begin
    data_q <= data_d;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) valid_q <= 1'b0;
    else             valid_q <= valid_d;
  end

  assign out_valid = valid_q;
  assign out_data  = data_q;
endmodule

// File: rtl/rot_unit_chk.sv
module rot_unit_chk #(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned AMT_W  = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rst_sync_n,
  input logic              in_valid,
  input logic              in_word,
  input logic [AMT_W-1:0]  in_amt,
  input logic [DATA_W-1:0] in_data,
  input logic              out_valid,
  input logic [DATA_W-1:0] out_data
);
  localparam int unsigned HALF_W = DATA_W / 2;

  // R5
  p_valid_follows_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    in_valid |=> out_valid);
  p_idle_follows_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !in_valid |=> !out_valid);
  // R6
  p_hold_when_idle_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !in_valid |=> $stable(out_data));
  // R7
  p_reset_clears_r7: assert property (@(posedge clk) !rst_n |-> !out_valid);
  // R4
  p_word_halves_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (in_valid && in_word) |=> (out_data[DATA_W-1:HALF_W] == out_data[HALF_W-1:0]));
  // R1
  p_dword_bits_kept_r1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (in_valid && !in_word) |=> ($countones(out_data) == $countones($past(in_data))));
  // R3
  p_zero_amount_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (in_valid && !in_word && in_amt == '0) |=> (out_data == $past(in_data)));
endmodule

bind rot_unit rot_unit_chk #(.DATA_W(DATA_W), .AMT_W(AMT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n),
  .in_valid(in_valid), .in_word(in_word), .in_amt(in_amt), .in_data(in_data),
  .out_valid(out_valid), .out_data(out_data)
);

// File: tb/tb_rot_unit.sv
`timescale 1ns/1ps
module tb_rot_unit;
  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic        in_word;
  logic [5:0]  in_amt;
  logic [63:0] in_data;
  logic        out_valid;
  logic [63:0] out_data;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  rot_unit dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word),
    .in_amt(in_amt), .in_data(in_data), .out_valid(out_valid), .out_data(out_data)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [63:0] ref_rot(input logic [63:0] v, input logic [5:0] n,
                                          input logic word);
    logic [63:0] s;
    s = word ? {v[31:0], v[31:0]} : v;
    if (n == 0) return s;
    return (s << n) | (s >> (7'd64 - {1'b0, n}));
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // drive at negedge, result visible at next negedge
  task automatic op(input string req, input logic [63:0] v, input logic [5:0] n,
                    input logic word);
    in_valid = 1'b1; in_word = word; in_amt = n; in_data = v;
    @(negedge clk);
    check({req, " data"}, out_data, ref_rot(v, n, word));
    check({req, " valid"}, {63'd0, out_valid}, 64'd1);
    in_valid = 1'b0;
  endtask

  initial begin
    #400000;
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    logic [63:0] held;
    logic [63:0] exp_prev;
    logic        have_prev;
    void'($urandom(32'h5eed_1234));
    rst_n = 1'b0; in_valid = 1'b0; in_word = 1'b0; in_amt = '0; in_data = '0;
    repeat (3) @(negedge clk);
    check("R7 reset valid", {63'd0, out_valid}, 64'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R7 valid after release", {63'd0, out_valid}, 64'd0);

    op("R1 rot10", 64'hdeadbeef12345678, 6'd10, 1'b0);
    check("R1 known 10", out_data, 64'hb6fbbc48d159e37a);
    op("R1 rot35", 64'hdeadbeef12345678, 6'd35, 1'b0);
    check("R1 known 35", out_data, 64'h91a2b3c6f56df778);
    op("R4 word10", 64'h00000000deadbeef, 6'd10, 1'b1);
    check("R4 known w10", out_data, 64'hb6fbbf7ab6fbbf7a);
    op("R4 word17", 64'h00000000deadbeef, 6'd17, 1'b1);
    check("R4 known w17", out_data[31:0], 64'h7ddfbd5b);
    op("R2 upper ignored", 64'h123456789abcdef0, 6'd21, 1'b1);
    op("R3 zero dword", 64'hfedcba9876543210, 6'd0, 1'b0);
    check("R3 identity", out_data, 64'hfedcba9876543210);
    op("R3 zero word", 64'hffff0000a5a5c3c3, 6'd0, 1'b1);
    check("R3 word dup", out_data, 64'ha5a5c3c3a5a5c3c3);
    op("R8 amt63", 64'h8000000000000001, 6'd63, 1'b0);
    check("R8 right by one", out_data, 64'hc000000000000000);

    // R6: idle cycle with new inputs must not disturb output
    held = out_data;
    in_valid = 1'b0; in_word = 1'b0; in_amt = 6'd7; in_data = 64'h0123456789abcdef;
    @(negedge clk);
    check("R6 hold data", out_data, held);
    check("R5 idle valid", {63'd0, out_valid}, 64'd0);

    // random back-to-back stream with random gaps
    have_prev = 1'b0; exp_prev = '0;
    for (int i = 0; i < 400; i++) begin
      logic        v;
      logic [63:0] d;
      logic [5:0]  a;
      logic        w;
      v = ($urandom % 4) != 0;
      d = {$urandom, $urandom};
      a = 6'($urandom);
      w = 1'($urandom);
      in_valid = v; in_data = d; in_amt = a; in_word = w;
      @(negedge clk);
      if (v) begin
        exp_prev = ref_rot(d, a, w);
        have_prev = 1'b1;
      end
      check("R5 random valid", {63'd0, out_valid}, {63'd0, v});
      if (have_prev) check(w && v ? "R2 random word" : "R1/R6 random", out_data, exp_prev);
    end
    in_valid = 1'b0;

    // mid-run reset
    op("R5 before reset", 64'h1, 6'd1, 1'b0);
    in_valid = 1'b1;
    #1 rst_n = 1'b0;
    #1;
    check("R7 async clear", {63'd0, out_valid}, 64'd0);
    in_valid = 1'b0;
    @(negedge clk);
    check("R7 held in reset", {63'd0, out_valid}, 64'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    op("R1 after reset", 64'h00000000000000ff, 6'd60, 1'b0);

    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule